// File: doc/BRIEF.md
# CORDIC Twiddle Rotator with Phase Accumulator

This block multiplies complex fixed-point samples by FFT twiddle factors without any multiplier. Each sample is rotated in a pipelined CORDIC that works in rotation mode and uses only adders, subtractors and arithmetic shifts. The rotation angle is not looked up in a table. A running phase register holds the base angle of the current butterfly, k times the per-butterfly step. Each sample carries a lane code that selects 0, 1, 2 or 3 times that base angle. The 2x and 3x multiples come from a shift and from a shift plus an add.

A radix-4 butterfly feeds its four inputs in lane order. Lane 0 bypasses the rotation. Lanes 1 to 3 receive the first, second and third twiddle. An accepted lane-3 sample closes the butterfly and adds the step to the phase register. A start pulse restarts the sequence at k = 0. Phase is a 16-bit unsigned value in which 65536 is one full turn. For forward FFT twiddles the step is the two's-complement phase of -1/N turn. For example, N = 16 uses a step of 61440.

The two top phase bits, after rounding, pick a pre-rotation by a multiple of a quarter turn, so the sixteen CORDIC stages only have to cover ±1/8 turn. A shift-add constant multiplier removes the CORDIC gain. The result is then rounded to nearest and saturated back to the sample width. Latency is fixed at 18 clocks, and the block accepts a new sample on every clock.

Top module: `cordic_twiddle_rotator`

## Requirements
- R1: A valid sample with lane code 0 appears at the output with both components exactly equal to the input.
- R2: A valid sample with lane code L (1, 2 or 3) is rotated counterclockwise by phase L·B mod 65536, where B is the base phase and 65536 is a full turn. Each output is within 4 LSB of i·cos(a) − q·sin(a) and i·sin(a) + q·cos(a). The rotation uses only adds, subtracts and shifts.
- R3: When start is high, the sample accepted in that cycle uses base phase 0, and the base phase restarts from 0 (plus the step if that sample has lane code 3).
- R4: The base phase grows by the step input only on a clock with a valid lane-3 sample. In all other cycles it holds, whatever the value of step.
- R5: Each accepted sample produces its output exactly 18 clocks later. While reset is active, out_valid, out_i and out_q are zero.
- R6: One sample is accepted per clock with no gaps required. Each accepted sample yields exactly one output, and outputs come out in input order.
- R7: Rotated results are rounded to nearest and clamped to the range −2^(DW−1) to 2^(DW−1)−1.
- R8: Every phase in the full turn is handled. After the quarter-turn pre-rotation, the residual angle lies in −8192 to 8191 phase units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Restart the butterfly sequence at k = 0 |
| step | input | 16 | Per-butterfly phase increment (65536 = one turn) |
| in_valid | input | 1 | Input sample valid |
| in_lane | input | 2 | Lane code: 0 bypass, 1..3 phase multiple |
| in_i | input | DW | Input real part, two's complement |
| in_q | input | DW | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_i | output | DW | Rotated real part |
| out_q | output | DW | Rotated imaginary part |

## Verification
The bench uses the default build: 12-bit samples, 16 stages and 4 guard bits. With these values full-scale inputs can exceed the output range after rotation, so the saturation path is reached. A step of 1/64 turn walks all four quadrant pre-rotations and both residual signs in one sweep. Radix-4 sequences with N = 16, an irregular step with idle gaps, a restart in the middle of a butterfly, and 45-degree steps on full-scale corners give the lane multiples, the restart rule and the clamp distinct, known angles to compare against real-valued cosine and sine.

// File: rtl/cordic_twiddle_pkg.sv
package cordic_twiddle_pkg;

  localparam int PHASE_W    = 16;
  localparam int MAX_STAGES = 16;

  typedef enum logic [1:0] {
    LANE_P0 = 2'd0,
    LANE_P1 = 2'd1,
    LANE_P2 = 2'd2,
    LANE_P3 = 2'd3
  } lane_e;

  // arctan(2^-idx) in phase units, 65536 per turn
  function automatic logic signed [PHASE_W-1:0] atan_step(input int idx);
    case (idx)
      0:  return 16'sd8192;
      1:  return 16'sd4836;
      2:  return 16'sd2555;
      3:  return 16'sd1297;
      4:  return 16'sd651;
      5:  return 16'sd326;
      6:  return 16'sd163;
      7:  return 16'sd81;
      8:  return 16'sd41;
      9:  return 16'sd20;
      10: return 16'sd10;
      11: return 16'sd5;
      12: return 16'sd3;
      13: return 16'sd1;
      14: return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction

  // Phase multiple for a lane: x0, x1, x2 (shift), x3 (shift plus add)
  function automatic logic [PHASE_W-1:0] lane_angle(input lane_e lane,
                                                     input logic [PHASE_W-1:0] base);
    case (lane)
      LANE_P0: return '0;
      LANE_P1: return base;
      LANE_P2: return base << 1;
      default: return (base << 1) + base;
    endcase
  endfunction

endpackage

// File: rtl/twiddle_phase_gen.sv
module twiddle_phase_gen
  import cordic_twiddle_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               in_valid,
  input  lane_e              in_lane,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] angle,
  output logic               bypass,
  output logic [PHASE_W-1:0] acc_q
);

  logic [PHASE_W-1:0] base;
  logic [PHASE_W-1:0] acc_d;
  logic               bfly_done;

  assign bfly_done = in_valid && (in_lane == LANE_P3);

  always_comb begin
    base  = start ? '0 : acc_q;
    acc_d = bfly_done ? base + step : base;
  end

  assign angle  = lane_angle(in_lane, base);
  assign bypass = (in_lane == LANE_P0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/cordic_prerotate.sv
module cordic_prerotate
  import cordic_twiddle_pkg::*;
#(
  parameter int DW = 12,
  parameter int GB = 4,
  parameter int IW = DW + 2 + GB
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      bypass,
  input  logic signed [DW-1:0]      in_i,
  input  logic signed [DW-1:0]      in_q,
  input  logic [PHASE_W-1:0]        angle,
  output logic                      v_q,
  output logic                      b_q,
  output logic signed [IW-1:0]      x_q,
  output logic signed [IW-1:0]      y_q,
  output logic signed [PHASE_W-1:0] z_q
);

  localparam logic [PHASE_W-1:0] HALF_QUAD = PHASE_W'(1 << (PHASE_W - 3));

  logic [1:0]                quad;
  logic signed [IW-1:0]      ex, ey, xr, yr;
  logic signed [PHASE_W-1:0] res;

  always_comb begin
    quad = bypass ? 2'd0 : 2'((angle + HALF_QUAD) >> (PHASE_W - 2));
    res  = bypass ? '0 : signed'(angle - {quad, {(PHASE_W-2){1'b0}}});
    ex   = IW'(in_i) <<< GB;
    ey   = IW'(in_q) <<< GB;
    case (quad)
      2'd0:    begin xr = ex;  yr = ey;  end
      2'd1:    begin xr = -ey; yr = ex;  end
      2'd2:    begin xr = -ex; yr = -ey; end
      default: begin xr = ey;  yr = -ex; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0; b_q <= 1'b0; x_q <= '0; y_q <= '0; z_q <= '0;
    end else begin
      v_q <= in_valid; b_q <= bypass; x_q <= xr; y_q <= yr; z_q <= res;
    end
  end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_twiddle_pkg::*;
#(
  parameter int IW  = 18,
  parameter int IDX = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      v_in,
  input  logic                      b_in,
  input  logic signed [IW-1:0]      x_in,
  input  logic signed [IW-1:0]      y_in,
  input  logic signed [PHASE_W-1:0] z_in,
  output logic                      v_out,
  output logic                      b_out,
  output logic signed [IW-1:0]      x_out,
  output logic signed [IW-1:0]      y_out,
  output logic signed [PHASE_W-1:0] z_out
);

  localparam logic signed [PHASE_W-1:0] ATAN = atan_step(IDX);

  logic signed [IW-1:0]      xs, ys, xn, yn;
  logic signed [PHASE_W-1:0] zn;

  always_comb begin
    xs = x_in >>> IDX;
    ys = y_in >>> IDX;
    if (b_in) begin
      xn = x_in; yn = y_in; zn = z_in;
    end else if (!z_in[PHASE_W-1]) begin
      xn = x_in - ys; yn = y_in + xs; zn = z_in - ATAN;
    end else begin
      xn = x_in + ys; yn = y_in - xs; zn = z_in + ATAN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0; b_out <= 1'b0; x_out <= '0; y_out <= '0; z_out <= '0;
    end else begin
      v_out <= v_in; b_out <= b_in; x_out <= xn; y_out <= yn; z_out <= zn;
    end
  end

endmodule

// File: rtl/cordic_gain_out.sv
module cordic_gain_out #(
  parameter int DW = 12,
  parameter int GB = 4,
  parameter int IW = DW + 2 + GB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic                 b_in,
  input  logic signed [IW-1:0] x_in,
  input  logic signed [IW-1:0] y_in,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int WW = IW + 16;
  localparam int SH = 14 + GB;
  localparam logic signed [WW-1:0] HALF = WW'(1) <<< (SH - 1);
  localparam logic signed [WW-1:0] HI   = WW'((2 ** (DW - 1)) - 1);
  localparam logic signed [WW-1:0] LO   = WW'(-(2 ** (DW - 1)));

  // Gain 1/1.6468 ~ 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-12 + 2^-14, then round and clamp
  function automatic logic signed [DW-1:0] scale_sat(input logic signed [IW-1:0] v,
                                                    input logic byp);
    logic signed [WW-1:0] e, s, r;
    e = WW'(v);
    if (byp) begin
      r = e >>> GB;
    end else begin
      s = (e <<< 13) + (e <<< 11) - (e <<< 8) - (e <<< 5) - (e <<< 2) + e;
      r = (s + HALF) >>> SH;
    end
    if (r > HI) r = HI;
    if (r < LO) r = LO;
    return r[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_i <= '0; out_q <= '0;
    end else begin
      out_valid <= v_in;
      out_i     <= scale_sat(x_in, b_in);
      out_q     <= scale_sat(y_in, b_in);
    end
  end

endmodule

// File: rtl/cordic_twiddle_rotator.sv
module cordic_twiddle_rotator
  import cordic_twiddle_pkg::*;
#(
  parameter int DW   = 12,
  parameter int NSTG = 16,
  parameter int GB   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [15:0]          step,
  input  logic                 in_valid,
  input  logic [1:0]           in_lane,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int IW = DW + 2 + GB;

  logic [PHASE_W-1:0] acc_phase;
  logic [PHASE_W-1:0] angle;
  logic               byp0;

  logic                      stg_v [0:NSTG];
  logic                      stg_b [0:NSTG];
  logic signed [IW-1:0]      stg_x [0:NSTG];
  logic signed [IW-1:0]      stg_y [0:NSTG];
  logic signed [PHASE_W-1:0] stg_z [0:NSTG];

  // Named events for the checker
  logic                      pre_valid;
  logic signed [PHASE_W-1:0] pre_res;
  logic signed [PHASE_W-1:0] final_res;
  assign pre_valid = stg_v[0];
  assign pre_res   = stg_z[0];
  assign final_res = stg_z[NSTG];

  twiddle_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_lane(lane_e'(in_lane)), .step(step),
    .angle(angle), .bypass(byp0), .acc_q(acc_phase)
  );

  cordic_prerotate #(.DW(DW), .GB(GB), .IW(IW)) u_pre (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bypass(byp0),
    .in_i(in_i), .in_q(in_q), .angle(angle),
    .v_q(stg_v[0]), .b_q(stg_b[0]), .x_q(stg_x[0]), .y_q(stg_y[0]), .z_q(stg_z[0])
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    cordic_stage #(.IW(IW), .IDX(g)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .v_in(stg_v[g]), .b_in(stg_b[g]), .x_in(stg_x[g]), .y_in(stg_y[g]), .z_in(stg_z[g]),
      .v_out(stg_v[g+1]), .b_out(stg_b[g+1]), .x_out(stg_x[g+1]), .y_out(stg_y[g+1]),
      .z_out(stg_z[g+1])
    );
  end

  cordic_gain_out #(.DW(DW), .GB(GB), .IW(IW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .v_in(stg_v[NSTG]), .b_in(stg_b[NSTG]), .x_in(stg_x[NSTG]), .y_in(stg_y[NSTG]),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

endmodule

// File: rtl/cordic_twiddle_checker.sv
module cordic_twiddle_checker
  import cordic_twiddle_pkg::*;
#(
  parameter int DW   = 12,
  parameter int NSTG = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic [15:0]               step,
  input logic                      in_valid,
  input logic [1:0]                in_lane,
  input logic signed [DW-1:0]      in_i,
  input logic signed [DW-1:0]      in_q,
  input logic                      out_valid,
  input logic signed [DW-1:0]      out_i,
  input logic signed [DW-1:0]      out_q,
  input logic [PHASE_W-1:0]        acc_phase,
  input logic                      pre_valid,
  input logic signed [PHASE_W-1:0] pre_res,
  input logic signed [PHASE_W-1:0] final_res
);

  localparam int LAT = NSTG + 2;

  logic [LAT-1:0]        vpipe, bpipe;
  logic signed [DW-1:0]  ipipe [LAT];
  logic signed [DW-1:0]  qpipe [LAT];
  logic [5:0]            age;
  logic                  lane3_acc;

  assign lane3_acc = in_valid && (in_lane == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpipe <= '0; bpipe <= '0; age <= '0;
      for (int k = 0; k < LAT; k++) begin ipipe[k] <= '0; qpipe[k] <= '0; end
    end else begin
      vpipe <= {vpipe[LAT-2:0], in_valid};
      bpipe <= {bpipe[LAT-2:0], in_valid && (in_lane == 2'd0)};
      ipipe[0] <= in_i; qpipe[0] <= in_q;
      for (int k = 1; k < LAT; k++) begin ipipe[k] <= ipipe[k-1]; qpipe[k] <= qpipe[k-1]; end
      if (age < 6'(LAT)) age <= age + 6'd1;
    end
  end

  a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6'(LAT)) |-> (out_valid == vpipe[LAT-1]));

  a_r1_lane0_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6'(LAT)) && vpipe[LAT-1] && bpipe[LAT-1] |->
      (out_i == ipipe[LAT-1]) && (out_q == qpipe[LAT-1]));

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start && !lane3_acc |=> (acc_phase == '0));

  a_r3_start_with_close: assert property (@(posedge clk) disable iff (!rst_n)
    start && lane3_acc |=> (acc_phase == $past(step)));

  a_r4_acc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !start && lane3_acc |=> (acc_phase == $past(acc_phase) + $past(step)));

  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !lane3_acc |=> $stable(acc_phase));

  a_r8_residual_octant: assert property (@(posedge clk) disable iff (!rst_n)
    pre_valid |-> (pre_res >= -16'sd8192) && (pre_res <= 16'sd8191));

  a_r2_residual_converged: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6'(LAT)) |-> (final_res >= -16'sd8) && (final_res <= 16'sd8));

endmodule

bind cordic_twiddle_rotator cordic_twiddle_checker #(.DW(DW), .NSTG(NSTG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step(step), .in_valid(in_valid),
  .in_lane(in_lane), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q), .acc_phase(acc_phase), .pre_valid(pre_valid),
  .pre_res(pre_res), .final_res(final_res)
);

// File: tb/sim_cordic_twiddle_rotator.sv
module sim_cordic_twiddle_rotator;

  localparam int  CLK_PERIOD = 10;
  localparam int  DW   = 12;
  localparam int  NSTG = 16;
  localparam int  LAT  = NSTG + 2;
  localparam int  TURN = 65536;
  localparam int  MAXV = (1 << (DW - 1)) - 1;
  localparam int  MINV = -(1 << (DW - 1));
  localparam real PI   = 3.14159265358979323846;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [15:0]          step = '0;
  logic                 in_valid = 1'b0;
  logic [1:0]           in_lane = '0;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_i, out_q;

  cordic_twiddle_rotator #(.DW(DW), .NSTG(NSTG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .in_valid(in_valid),
    .in_lane(in_lane), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_checks = 0, n_fail = 0;
  int    e_i [0:2047], e_q [0:2047], e_cyc [0:2047], e_tol [0:2047];
  string e_req [0:2047];
  int    wr = 0, rd = 0, model_acc = 0;
  bit    finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd_clamp(real r);
    int v;
    v = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    if (v > MAXV) v = MAXV;
    if (v < MINV) v = MINV;
    return v;
  endfunction

  // Drive one sample and record its expected output
  task automatic send(bit st, int lane, int x, int y, int stp, string req);
    int ph;
    real a;
    @(negedge clk);
    if (st) model_acc = 0;
    ph = (lane * model_acc) % TURN;
    if (lane == 0) begin
      e_i[wr] = x; e_q[wr] = y; e_tol[wr] = 0;
    end else begin
      a = 2.0 * PI * real'(ph) / real'(TURN);
      e_i[wr] = rnd_clamp(real'(x) * $cos(a) - real'(y) * $sin(a));
      e_q[wr] = rnd_clamp(real'(x) * $sin(a) + real'(y) * $cos(a));
      e_tol[wr] = 4;
    end
    e_cyc[wr] = cyc + LAT;
    e_req[wr] = req;
    wr++;
    start = st; step = 16'(stp); in_valid = 1'b1;
    in_lane = 2'(lane); in_i = DW'(x); in_q = DW'(y);
    if (lane == 3) model_acc = (model_acc + stp) % TURN;
  endtask

  // Idle cycles with a junk step value that must be ignored (R4)
  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0; in_lane = 2'(k); step = 16'hBEEF;
    end
  endtask

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (rd >= wr) begin
        check(1'b0, "R6", "output with no pending input", rd, wr);
      end else begin
        check(cyc == e_cyc[rd], "R5", "output cycle", cyc, e_cyc[rd]);
        check(absd(int'(out_i), e_i[rd]) <= e_tol[rd], e_req[rd], "out_i", int'(out_i), e_i[rd]);
        check(absd(int'(out_q), e_q[rd]) <= e_tol[rd], e_req[rd], "out_q", int'(out_q), e_q[rd]);
        rd++;
      end
    end
  end

  task automatic drain();
    for (int k = 0; k < 4 * LAT && rd < wr; k++) @(negedge clk);
    check(rd == wr, "R6", "outputs received vs samples sent", rd, wr);
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d outputs", rd, wr);
      summary();
    end
  end

  initial begin
    // R5: reset state
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R5", "out_valid in reset", int'(out_valid), 0);
    check(out_i == '0, "R5", "out_i in reset", int'(out_i), 0);
    check(out_q == '0, "R5", "out_q in reset", int'(out_q), 0);
    rst_n = 1'b1;
    idle(3);

    // R1, R2, R4: radix-4 butterflies of a 16-point FFT, back to back (R6)
    for (int b = 0; b < 4; b++)
      for (int l = 0; l < 4; l++)
        send(b == 0 && l == 0, l, ((b * 173 + l * 409) % 1801) - 900,
             ((b * 311 + l * 97) % 1601) - 800, 61440, (l == 0) ? "R1" : "R2");
    idle(2);

    // R8: 1/64-turn step walks the whole circle on every lane
    for (int b = 0; b < 64; b++)
      for (int l = 0; l < 4; l++)
        send(b == 0 && l == 0, l, ((b * 59 + l * 233) % 3001) - 1500,
             ((b * 131 + l * 71) % 2801) - 1400, 1024, (l == 0) ? "R1" : "R8");
    idle(1);

    // R4: irregular step with gaps; junk step during idle is ignored
    for (int b = 0; b < 20; b++)
      for (int l = 0; l < 4; l++) begin
        send(b == 0 && l == 0, l, ((b * 211 + l * 37) % 2001) - 1000,
             ((b * 83 + l * 401) % 2001) - 1000, 12345, "R4");
        idle((b + l) % 3);
      end

    // R3: restart in the middle of a butterfly
    for (int b = 0; b < 5; b++)
      for (int l = 0; l < 4; l++)
        send(b == 0 && l == 0, l, 700 - b * 50, -300 + l * 90, 5000, "R4");
    send(1'b0, 1, 1200, -400, 5000, "R4");
    send(1'b1, 2, 900, 650, 5000, "R3");
    send(1'b0, 3, -1100, 300, 5000, "R3");
    send(1'b0, 1, 1500, 200, 5000, "R3");
    send(1'b0, 2, -500, -1500, 5000, "R3");
    idle(2);

    // R7: 45-degree step with full-scale corners drives the clamp
    send(1'b1, 0, MAXV, MAXV, 8192, "R1");
    send(1'b0, 1, 100, 100, 8192, "R7");
    send(1'b0, 2, 100, -100, 8192, "R7");
    send(1'b0, 3, 100, 50, 8192, "R7");
    send(1'b0, 0, MINV, MINV, 8192, "R1");
    send(1'b0, 1, MAXV, MAXV, 8192, "R7");
    send(1'b0, 2, MINV, MINV, 8192, "R7");
    send(1'b0, 3, MAXV, MINV, 8192, "R7");
    send(1'b0, 0, 1, -1, 8192, "R1");
    send(1'b0, 1, MINV, MAXV, 8192, "R7");
    send(1'b0, 2, MAXV, 0, 8192, "R7");
    send(1'b0, 3, 0, MINV, 8192, "R7");
    idle(1);

    drain();
    idle(LAT + 2);
    check(rd == wr, "R6", "no extra outputs after drain", rd, wr);
    summary();
  end

endmodule